// File: doc/BRIEF.md
# Prescaled Timer with Coherent Byte Readout

This block is a 16-bit free-running up-counter that a CPU reads through an 8-bit synchronous register bus. A 3-bit prescaler select field picks the rate at which the counter advances. Seven of its codes divide the bus clock by a power of two from 1 to 64. The eighth code makes the counter advance on rising edges of an external clock pin, which is first synchronized to the bus clock. Software can clear the counter and the prescaler phase with a strobe bit in the control register.

The count is read one byte at a time. Reading the high byte copies the low byte of that same instant into a holding buffer. The following low-byte read returns the buffered byte and releases the buffer. A CPU that reads high and then low therefore always gets one coherent 16-bit value, however long it waits between the two reads (for instance while halted at a debug break).

Top module: `prescaled_timer`

## Requirements
- R1: Reset (rst high at a clock edge) clears the counter, the prescaler divider, the read data register, the holding buffer and its latched flag, and sets the prescaler select field to 000.
- R2: With prescaler select code k in 0..6, the counter reads floor(n / 2^k) (mod 2^16) after the n-th clock edge that follows the edge at which a reset or clear took effect.
- R3: With prescaler select code 7, the counter advances once for each rising edge of `ext_clk`, after a two-flop synchronizer, and does not advance on bus clock cycles without such an edge. `ext_clk` must be slower than half the bus clock.
- R4: Register map on `bus_addr`: 0 is control (bits [2:0] prescaler select, read/write; bit 4 written as 1 is a clear strobe and reads as 0; other bits read 0), 1 is the count high byte, 2 is the count low byte, and 3 reads 0. Read data is registered: it appears on `bus_rdata` after the clock edge at which `bus_rd` is high and holds until the next read.
- R5: Writes to addresses 1, 2 and 3 are ignored: they change neither the count nor the prescaler select field.
- R6: A high-byte read while the buffer is free copies the current low count byte into the holding buffer and latches it; the next low-byte read returns the buffered byte and releases the buffer.
- R7: While the buffer is latched, further high-byte reads return the current high byte but do not reload the buffer, however many cycles pass, until a low-byte read releases it.
- R8: A low-byte read while the buffer is free returns the current low count byte.
- R9: Writing the control register with bit 4 set clears the counter and the prescaler divider at the clock edge after the write edge; the prescaler field written in the same write is already in effect then.
- R10: The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External count clock, asynchronous to `clk` |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Each of the seven divide codes is run for a different number of cycles, and both bytes are compared with floor(n / 2^k). This separates the divide ratios from one another and catches a wrong divider phase after a clear. Pulses on the external pin, with the bus clock still running, separate a pin edge from a bus tick. A long run past 0xFFFF shows the wrap, and high, high, low, low read sequences spaced many cycles apart tell a buffer that holds apart from one that reloads or never releases.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  localparam int ADDR_W  = 2;
  localparam int CLR_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [PS_W-1:0] psel,
  input  logic            ext_i,
  output logic            tick
);
  localparam int NSEL  = 1 << PS_W;
  localparam int DIV_W = NSEL - 2;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       sync_q;
  logic             ext_rise;
  logic [NSEL-1:0]  tick_opt;

  // free-running divider, phase restarted by the clear strobe
  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // two synchronizer stages plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], ext_i};
  end
  assign ext_rise = sync_q[1] & ~sync_q[2];

  // one enable option per select code; the last code is the pin
  generate
    for (genvar k = 0; k < NSEL - 1; k++) begin : g_rate
      if (k == 0) begin : g_full
        assign tick_opt[k] = 1'b1;
      end else begin : g_div
        assign tick_opt[k] = &div_q[k-1:0];
      end
    end
  endgenerate
  assign tick_opt[NSEL-1] = ext_rise;

  assign tick = tick_opt[psel];
endmodule

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ptmr_regs.sv
`timescale 1ns/1ps
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int PS_W  = 3,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [PS_W-1:0]   psel,
  output logic              clr,
  output logic [BUS_W-1:0]  rdata,
  output logic              held,
  output logic [BUS_W-1:0]  hold_byte
);
  logic ctrl_wr;
  logic unused_bits;

  assign ctrl_wr     = wr_en && (reg_addr_e'(addr) == REG_CTRL);
  assign unused_bits = ^{wdata, cnt};

  // control field and the registered clear strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      psel <= '0;
      clr  <= 1'b0;
    end else begin
      clr <= ctrl_wr && wdata[CLR_BIT];
      if (ctrl_wr) psel <= wdata[PS_W-1:0];
    end
  end

  // registered readout with the coherent low-byte buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      held      <= 1'b0;
      hold_byte <= '0;
    end else if (rd_en) begin
      case (reg_addr_e'(addr))
        REG_CTRL:   rdata <= BUS_W'(psel);
        REG_CNT_HI: begin
          rdata <= cnt[CNT_W-1 -: BUS_W];
          if (!held) begin
            hold_byte <= cnt[BUS_W-1:0];
            held      <= 1'b1;
          end
        end
        REG_CNT_LO: begin
          rdata <= held ? hold_byte : cnt[BUS_W-1:0];
          held  <= 1'b0;
        end
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int PS_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int CNT_W = 2 * BUS_W;

  logic [PS_W-1:0]  psel;
  logic             sw_clr;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             held;
  logic [BUS_W-1:0] hold_byte;

  ptmr_regs #(.BUS_W(BUS_W), .PS_W(PS_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd_en(bus_rd), .wr_en(bus_wr),
    .wdata(bus_wdata), .cnt(cnt_q), .psel(psel), .clr(sw_clr),
    .rdata(bus_rdata), .held(held), .hold_byte(hold_byte)
  );

  ptmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .clr(sw_clr), .psel(psel), .ext_i(ext_clk), .tick(tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(sw_clr), .tick(tick), .cnt(cnt_q)
  );
endmodule

// File: rtl/ptmr_chk.sv
`timescale 1ns/1ps
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int PS_W  = 3,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [PS_W-1:0]   psel,
  input logic              held,
  input logic [BUS_W-1:0]  hold_byte,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr
);
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  a_r2_step_bounded: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r2_div1_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (!clr && psel == '0) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick) |=> $stable(cnt));

  a_r7_buffer_holds: assert property (@(posedge clk) disable iff (rst)
    (held && !(rd && reg_addr_e'(addr) == REG_CNT_LO)) |=> (held && $stable(hold_byte)));

  a_r5_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr && reg_addr_e'(addr) != REG_CTRL) |=> $stable(psel));

  a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr && tick && cnt == '1) |=> (cnt == '0));
endmodule

bind prescaled_timer ptmr_chk #(.BUS_W(BUS_W), .PS_W(PS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(sw_clr), .tick(tick), .cnt(cnt_q), .psel(psel),
  .held(held), .hold_byte(hold_byte), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr)
);

// File: tb/sim_prescaled_timer.sv
`timescale 1ns/1ps
module sim_prescaled_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int clr_edge = 0;
  int rd_edge = 0;
  int wr_edge = 0;
  logic [7:0] rv;

  localparam int NVEC = 7;
  // each vector: prescaler code, cycles to wait before reading
  localparam int VEC_PS [NVEC] = '{0, 1, 2, 3, 4, 5, 6};
  localparam int VEC_WT [NVEC] = '{10, 37, 100, 260, 530, 1100, 3000};

  prescaled_timer u0 (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] model(input int edge_r, input int k);
    return 16'(((edge_r - 1 - clr_edge) >> k) & 32'hFFFF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and return at one
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    wr_edge = cyc;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    rd_edge = cyc;
    rv = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic clear_with(input logic [2:0] ps);
    bus_write(2'd0, 8'h10 | 8'(ps));
    clr_edge = wr_edge + 1;
  endtask

  initial begin
    #(190000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] e;
    logic [7:0]  hi1, lo_keep;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", int'(bus_rdata), 0);
    rst = 1'b0;
    clr_edge = cyc;
    // R1: prescaler field resets to divide-by-1, counter starts from zero
    bus_read(2'd0);
    chk("R1 prescaler field after reset", int'(rv), 0);
    bus_read(2'd1);
    e = model(rd_edge, 0);
    chk("R1 high byte after reset", int'(rv), int'(e[15:8]));
    bus_read(2'd2);
    chk("R1 low byte after reset", int'(rv), int'(e[7:0]));

    // R2 table walk over every divide code
    for (int i = 0; i < NVEC; i++) begin
      clear_with(3'(VEC_PS[i]));
      repeat (VEC_WT[i]) @(negedge clk);
      bus_read(2'd1);
      e = model(rd_edge, VEC_PS[i]);
      chk($sformatf("R2 code %0d high", VEC_PS[i]), int'(rv), int'(e[15:8]));
      bus_read(2'd2);
      chk($sformatf("R2 code %0d low", VEC_PS[i]), int'(rv), int'(e[7:0]));
    end

    // R4: control readback, clear bit reads 0, spare address reads 0
    bus_write(2'd0, 8'h13);
    bus_read(2'd0);
    chk("R4 control readback", int'(rv), 3);
    bus_read(2'd3);
    chk("R4 spare address", int'(rv), 0);

    // R5: writes to read-only addresses change nothing
    clear_with(3'd0);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hAA);
    bus_write(2'd3, 8'h07);
    repeat (5) @(negedge clk);
    bus_read(2'd1);
    e = model(rd_edge, 0);
    chk("R5 high after ro writes", int'(rv), int'(e[15:8]));
    bus_read(2'd2);
    chk("R5 low after ro writes", int'(rv), int'(e[7:0]));
    bus_read(2'd0);
    chk("R5 prescaler kept", int'(rv), 0);

    // R6 R7 R8: buffer holds across a second high read, then releases
    clear_with(3'd0);
    repeat (250) @(negedge clk);
    bus_read(2'd1);
    e = model(rd_edge, 0);
    hi1 = e[15:8];
    lo_keep = e[7:0];
    chk("R6 first high", int'(rv), int'(hi1));
    repeat (20) @(negedge clk);
    bus_read(2'd1);
    e = model(rd_edge, 0);
    chk("R7 second high is live", int'(rv), int'(e[15:8]));
    repeat (40) @(negedge clk);
    bus_read(2'd2);
    chk("R7 low keeps first capture", int'(rv), int'(lo_keep));
    repeat (3) @(negedge clk);
    bus_read(2'd2);
    e = model(rd_edge, 0);
    chk("R8 low after release is live", int'(rv), int'(e[7:0]));

    // R9: clear mid-count restarts from zero with the new code
    repeat (100) @(negedge clk);
    clear_with(3'd2);
    repeat (9) @(negedge clk);
    bus_read(2'd2);
    chk("R9 restart after clear", int'(rv), int'(model(rd_edge, 2)));

    // R3: external pin, bus clock alone does not count
    clear_with(3'd7);
    repeat (20) @(negedge clk);
    bus_read(2'd2);
    chk("R3 no pin edges", int'(rv), 0);
    for (int p = 0; p < 5; p++) begin
      ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    bus_read(2'd1);
    chk("R3 high after five pulses", int'(rv), 0);
    bus_read(2'd2);
    chk("R3 low after five pulses", int'(rv), 5);

    // R10: wrap past 0xFFFF
    clear_with(3'd0);
    repeat (65540) @(negedge clk);
    bus_read(2'd1);
    e = model(rd_edge, 0);
    chk("R10 high after wrap", int'(rv), int'(e[15:8]));
    bus_read(2'd2);
    chk("R10 low after wrap", int'(rv), int'(e[7:0]));

    // R1: reset releases a latched buffer
    repeat (30) @(negedge clk);
    bus_read(2'd1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rdata cleared by reset", int'(bus_rdata), 0);
    rst = 1'b0;
    clr_edge = cyc;
    repeat (7) @(negedge clk);
    bus_read(2'd2);
    chk("R1 buffer free after reset", int'(rv), int'(model(rd_edge, 0)));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule